// File: doc/BRIEF.md
# Prescaled Multi-Mode Compare Timer

The block is a free-standing timer core. An input clock feeds a programmable prescaler, and each time the prescaler completes a pass the 24-bit up counter advances by one. The counter is compared against a programmable compare value. A match sets a sticky match flag, which software clears by writing 1 to it. The match flag drives an interrupt line through an enable bit and can also raise a sticky wake flag. What happens on a match depends on one of four operating modes. In one-shot mode the counter stops. In periodic mode the counter reloads. In toggle mode the counter reloads and a square-wave output changes level. In continuous mode the counter keeps running.

Software reaches the block through a flat register port with four word addresses. Address 0 is the control word. Address 1 is the compare value. Address 2 is the status word, with write-1-to-clear flags. Address 3 is a read-only snapshot of the count. The snapshot follows the counter only while its load-enable bit is set. A debug-halt input freezes counting unless the control word says to ignore it.

A small state machine sequences the core. It has three states: IDLE, COUNT and FROZEN. These are its transitions:
- T_START (IDLE to COUNT): a control write sets the run bit.
- T_STOP (any state to IDLE): a control write clears the run bit.
- T_SOFT_RESET (any state to IDLE): a control write sets the soft-reset bit.
- T_ONESHOT_DONE (COUNT to IDLE): a match occurs in one-shot mode.
- T_HALT (COUNT to FROZEN): debug halt is high and not ignored.
- T_RESUME (FROZEN to COUNT): the halt condition goes away.

Top module: `cmp_timer`

## Requirements
- R1: After reset, all registers are zero, the state is IDLE, and irq, active, tog_out, wake_flag and snap are 0. Addresses: 0 control, 1 compare (bits 23:0), 2 status (bit0 match flag, bit1 wake flag, bit2 active, read-only), 3 snapshot (bits 23:0).
- R2: Control bits 7:0 hold the prescale value P. While running, the counter advances once every P+1 clocks. The first step comes P+1 clocks after the start write.
- R3: Control bits 10:9 select the mode: 00 one-shot, 01 periodic, 10 toggle, 11 continuous. In periodic mode, the step that would make the count equal the compare value instead reloads the count to 0 and sets the match flag.
- R4: In one-shot mode, a match sets the flag, reloads the count to 0 and moves to IDLE. The run bit then reads 0 and active is 0.
- R5: In toggle mode, each match reloads the count to 0 and inverts tog_out.
- R6: In continuous mode, a match sets the flag and the count keeps advancing past the compare value.
- R7: The match flag (status bit0) is cleared by writing 1 to it. Writing 0 leaves it unchanged. When a match and a clearing write fall in the same cycle, the flag stays set.
- R8: irq is high exactly while the match flag is set and the interrupt-enable bit (control bit 11) is 1.
- R9: A compare write restarts the count and the prescaler from 0 in one-shot, periodic and toggle modes. In continuous mode it leaves the count running.
- R10: A control write with the soft-reset bit (control bit 14) set clears the prescaler, the counter, tog_out and the run bit. The soft-reset bit itself reads as 0.
- R11: While the snapshot-enable bit (control bit 13) is 1, snap takes the counter value one clock later. While it is 0, snap holds its value.
- R12: While dbg_halt is high and the halt-ignore bit (control bit 15) is 0, the prescaler and counter hold and active stays 1. With the ignore bit set to 1, counting continues.
- R13: With wake enable (control bit 12) set to 1, a match sets the wake flag (status bit1). The wake flag is cleared by writing 1 to status bit1. With wake enable at 0, the wake flag stays 0.
- R14: A control write with the run bit (control bit 8) at 0 suspends counting and keeps the count. Setting the run bit again resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| snap | output | 24 | Counter snapshot register |
| active | output | 1 | Timer enabled (state COUNT or FROZEN) |
| tog_out | output | 1 | Toggle-mode square-wave output |
| irq | output | 1 | Match interrupt |
| wake_flag | output | 1 | Sticky wake flag |

## Verification
Two pairs of functions can fall in the same clock cycle.

The first pair is a hardware match and a software write-1 clear of the match flag. The bench provokes this by starting a periodic run with prescale 0 and compare 5, which puts matches at known edges. It then issues the clearing write on the tenth edge. The flag must read set after that edge. A second clearing write one edge later must leave it clear.

The second pair is a compare write and a counter step. Here the write must win in the restarting modes, so the snapshot shows a count rebuilt from zero. In continuous mode the step must continue undisturbed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SNAP = 2'd3;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_TOGGLE   = 2'b10,
        MODE_CONT     = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_FROZEN = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int CNT_W = 24,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              active,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cnt,
    output logic              run_set,
    output logic              run_clr,
    output logic              srst,
    output logic              cmp_wr,
    output logic [PS_W-1:0]   prescale,
    output tmr_mode_e         mode,
    output logic              irq_en,
    output logic              wake_en,
    output logic              snap_en,
    output logic              dbg_ign,
    output logic [CNT_W-1:0]  cmp,
    output logic              mflag,
    output logic              wflag,
    output logic [CNT_W-1:0]  snap
);

    // control-word field positions follow the prescale field
    localparam int B_RUN  = PS_W;
    localparam int B_MODE = PS_W + 1;
    localparam int B_IE   = PS_W + 3;
    localparam int B_WE   = PS_W + 4;
    localparam int B_SE   = PS_W + 5;
    localparam int B_SR   = PS_W + 6;
    localparam int B_DI   = PS_W + 7;

    logic wr_ctrl, wr_stat;
    logic unused_hi;

    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_stat   = wr_en && (wr_addr == ADDR_STAT);
    assign cmp_wr    = wr_en && (wr_addr == ADDR_CMP);
    assign srst      = wr_ctrl && wr_data[B_SR];
    assign run_set   = wr_ctrl && wr_data[B_RUN] && !wr_data[B_SR];
    assign run_clr   = wr_ctrl && !wr_data[B_RUN];
    assign unused_hi = ^wr_data[DW-1:CNT_W];

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prescale <= '0;
            mode     <= MODE_ONESHOT;
            irq_en   <= 1'b0;
            wake_en  <= 1'b0;
            snap_en  <= 1'b0;
            dbg_ign  <= 1'b0;
        end else if (wr_ctrl) begin
            prescale <= wr_data[PS_W-1:0];
            mode     <= tmr_mode_e'(wr_data[B_MODE +: 2]);
            irq_en   <= wr_data[B_IE];
            wake_en  <= wr_data[B_WE];
            snap_en  <= wr_data[B_SE];
            dbg_ign  <= wr_data[B_DI];
        end
    end

    // compare value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (cmp_wr) begin
            cmp <= wr_data[CNT_W-1:0];
        end
    end

    // sticky flags: hardware set has priority over a write-1 clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mflag <= 1'b0;
            wflag <= 1'b0;
        end else begin
            if (hit) begin
                mflag <= 1'b1;
            end else if (wr_stat && wr_data[0]) begin
                mflag <= 1'b0;
            end
            if (hit && wake_en) begin
                wflag <= 1'b1;
            end else if (wr_stat && wr_data[1]) begin
                wflag <= 1'b0;
            end
        end
    end

    // snapshot follows the counter only while enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (snap_en) begin
            snap <= cnt;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[PS_W-1:0]     = prescale;
                rd_data[B_RUN]        = active;
                rd_data[B_MODE +: 2]  = mode;
                rd_data[B_IE]         = irq_en;
                rd_data[B_WE]         = wake_en;
                rd_data[B_SE]         = snap_en;
                rd_data[B_DI]         = dbg_ign;
            end
            ADDR_CMP:  rd_data[CNT_W-1:0] = cmp;
            ADDR_STAT: rd_data[2:0]       = {active, wflag, mflag};
            ADDR_SNAP: rd_data[CNT_W-1:0] = snap;
        endcase
    end

endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_set,
    input  logic      run_clr,
    input  logic      srst,
    input  logic      hit,
    input  tmr_mode_e mode,
    input  logic      freeze,
    output logic      active,
    output logic      counting,
    output logic      frozen
);

    tmr_state_e state, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        if (srst) begin
            state_n = ST_IDLE;                          // T_SOFT_RESET
        end else if (run_clr) begin
            state_n = ST_IDLE;                          // T_STOP
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run_set) state_n = ST_COUNT;    // T_START
                end
                ST_COUNT: begin
                    if (hit && mode == MODE_ONESHOT && !run_set)
                        state_n = ST_IDLE;              // T_ONESHOT_DONE
                    else if (freeze)
                        state_n = ST_FROZEN;            // T_HALT
                end
                ST_FROZEN: begin
                    if (!freeze) state_n = ST_COUNT;    // T_RESUME
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        active   = 1'b0;
        counting = 1'b0;
        frozen   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COUNT:  begin active = 1'b1; counting = 1'b1; end
            ST_FROZEN: begin active = 1'b1; frozen = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic [PS_W-1:0]  prescale,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic             srst,
    input  logic             cmp_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             tog
);

    logic [PS_W-1:0]  presc;
    logic [CNT_W-1:0] cnt_inc;
    logic             restart;
    logic             tick;

    assign restart = srst || (cmp_wr && mode != MODE_CONT);
    assign tick    = counting && !restart && (presc >= prescale);
    assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    assign hit     = tick && (cnt_inc == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            cnt   <= '0;
            tog   <= 1'b0;
        end else if (restart) begin
            presc <= '0;
            cnt   <= '0;
            if (srst) tog <= 1'b0;
        end else if (counting) begin
            if (presc >= prescale) begin
                presc <= '0;
            end else begin
                presc <= presc + {{(PS_W-1){1'b0}}, 1'b1};
            end
            if (tick) begin
                if (hit) begin
                    unique case (mode)
                        MODE_ONESHOT:  cnt <= '0;
                        MODE_PERIODIC: cnt <= '0;
                        MODE_TOGGLE: begin
                            cnt <= '0;
                            tog <= ~tog;
                        end
                        MODE_CONT:     cnt <= cnt_inc;
                    endcase
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int CNT_W = 24,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              dbg_halt,
    output logic [CNT_W-1:0]  snap,
    output logic              active,
    output logic              tog_out,
    output logic              irq,
    output logic              wake_flag
);

    logic             run_set, run_clr, srst, cmp_wr;
    logic [PS_W-1:0]  prescale;
    tmr_mode_e        mode;
    logic             irq_en, wake_en, snap_en, dbg_ign;
    logic [CNT_W-1:0] cmp, cnt;
    logic             mflag, hit, counting, frozen, freeze;

    assign freeze = dbg_halt && !dbg_ign;
    assign irq    = mflag && irq_en;

    tmr_regs #(.PS_W(PS_W), .CNT_W(CNT_W), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .active   (active),
        .hit      (hit),
        .cnt      (cnt),
        .run_set  (run_set),
        .run_clr  (run_clr),
        .srst     (srst),
        .cmp_wr   (cmp_wr),
        .prescale (prescale),
        .mode     (mode),
        .irq_en   (irq_en),
        .wake_en  (wake_en),
        .snap_en  (snap_en),
        .dbg_ign  (dbg_ign),
        .cmp      (cmp),
        .mflag    (mflag),
        .wflag    (wake_flag),
        .snap     (snap)
    );

    tmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_set  (run_set),
        .run_clr  (run_clr),
        .srst     (srst),
        .hit      (hit),
        .mode     (mode),
        .freeze   (freeze),
        .active   (active),
        .counting (counting),
        .frozen   (frozen)
    );

    tmr_count #(.PS_W(PS_W), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .counting (counting),
        .prescale (prescale),
        .mode     (mode),
        .cmp      (cmp),
        .srst     (srst),
        .cmp_wr   (cmp_wr),
        .cnt      (cnt),
        .hit      (hit),
        .tog      (tog_out)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             mflag,
    input tmr_mode_e        mode,
    input logic             active,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             tog,
    input logic             srst,
    input logic             cmp_wr,
    input logic             run_set,
    input logic             snap_en,
    input logic [CNT_W-1:0] snap,
    input logic             frozen
);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (mode == MODE_PERIODIC || mode == MODE_TOGGLE) |=> cnt == '0);

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && mode == MODE_ONESHOT && !run_set |=> !active && cnt == '0);

    p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && mode == MODE_TOGGLE |=> tog != $past(tog));

    p_cont_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && mode == MODE_CONT |=> active && cnt == $past(cmp));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> mflag);

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !active && cnt == '0 && !tog);

    p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> snap == $past(snap));

    p_frozen_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !srst && !cmp_wr |=> cnt == $past(cnt));

endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .mflag   (mflag),
    .mode    (mode),
    .active  (active),
    .cnt     (cnt),
    .cmp     (cmp),
    .tog     (tog_out),
    .srst    (srst),
    .cmp_wr  (cmp_wr),
    .run_set (run_set),
    .snap_en (snap_en),
    .snap    (snap),
    .frozen  (frozen)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic        dbg_halt = 1'b0;
    logic [31:0] rd_data;
    logic [23:0] snap;
    logic        active, tog_out, irq, wake_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .snap(snap), .active(active),
        .tog_out(tog_out), .irq(irq), .wake_flag(wake_flag)
    );

    // ps, mode, cmp, edges after start, exp snap, exp flag, exp active, exp tog
    typedef struct packed {
        logic [7:0]  ps;
        logic [1:0]  md;
        logic [23:0] cm;
        logic [15:0] n;
        logic [23:0] sn;
        logic        fl;
        logic        ac;
        logic        tg;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{8'd0, 2'd1, 24'd5,  16'd4,  24'd3, 1'b0, 1'b1, 1'b0},
        '{8'd0, 2'd1, 24'd5,  16'd8,  24'd2, 1'b1, 1'b1, 1'b0},
        '{8'd3, 2'd1, 24'd4,  16'd10, 24'd2, 1'b0, 1'b1, 1'b0},
        '{8'd3, 2'd1, 24'd4,  16'd20, 24'd0, 1'b1, 1'b1, 1'b0},
        '{8'd0, 2'd0, 24'd6,  16'd4,  24'd3, 1'b0, 1'b1, 1'b0},
        '{8'd0, 2'd0, 24'd6,  16'd10, 24'd0, 1'b1, 1'b0, 1'b0},
        '{8'd0, 2'd2, 24'd3,  16'd5,  24'd1, 1'b1, 1'b1, 1'b1},
        '{8'd0, 2'd2, 24'd3,  16'd10, 24'd0, 1'b1, 1'b1, 1'b1},
        '{8'd0, 2'd3, 24'd3,  16'd8,  24'd7, 1'b1, 1'b1, 1'b0},
        '{8'd1, 2'd3, 24'd10, 16'd9,  24'd4, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // caller sits just after a falling edge; the next rising edge takes the write
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] cw(input logic [7:0] ps, input logic run, input logic [1:0] md,
                                       input logic ie, input logic we, input logic se,
                                       input logic sr, input logic di);
        return {16'h0, di, sr, se, we, ie, md, run, ps};
    endfunction

    task automatic setup(input logic [7:0] ps, input logic [1:0] md, input logic [23:0] cm,
                         input logic ie, input logic we, input logic se);
        wr(2'd0, cw(8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        wr(2'd2, 32'h3);
        wr(2'd1, {8'h0, cm});
        wr(2'd0, cw(ps, 1'b1, md, ie, we, se, 1'b0, 1'b0));
    endtask

    function automatic string mode_tag(input logic [1:0] md, input logic [7:0] ps);
        string s;
        case (md)
            2'd0: s = "R4 one-shot";
            2'd1: s = "R3 periodic";
            2'd2: s = "R5 toggle";
            default: s = "R6 continuous";
        endcase
        if (ps != 0) s = {s, " R2 prescale"};
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [23:0] a;

        run(3);
        rst_n = 1'b1;
        run(1);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 active", {31'b0, active}, 32'd0);
        chk("R1 tog_out", {31'b0, tog_out}, 32'd0);
        chk("R1 wake_flag", {31'b0, wake_flag}, 32'd0);
        chk("R1 snap", {8'b0, snap}, 32'd0);
        rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(2'd2, d); chk("R1 status", d, 32'd0);

        // table of mode / prescale vectors
        for (int i = 0; i < NVEC; i++) begin
            string t;
            t = mode_tag(VEC[i].md, VEC[i].ps);
            setup(VEC[i].ps, VEC[i].md, VEC[i].cm, 1'b1, 1'b0, 1'b1);
            run(int'(VEC[i].n));
            chk({t, " snap"}, {8'b0, snap}, {8'b0, VEC[i].sn});
            rd(2'd3, d); chk({t, " snap read"}, d, {8'b0, VEC[i].sn});
            rd(2'd2, d); chk({t, " flag"}, {31'b0, d[0]}, {31'b0, VEC[i].fl});
            chk({t, " active"}, {31'b0, active}, {31'b0, VEC[i].ac});
            chk({t, " tog_out"}, {31'b0, tog_out}, {31'b0, VEC[i].tg});
            chk("R8 irq follows flag", {31'b0, irq}, {31'b0, VEC[i].fl});
            chk("R13 wake stays low when disabled", {31'b0, wake_flag}, 32'd0);
        end

        // R9 compare write restarts periodic count
        setup(8'd0, 2'd1, 24'd20, 1'b0, 1'b0, 1'b1);
        run(10);
        wr(2'd1, 32'd30);
        run(3);
        chk("R9 periodic restart", {8'b0, snap}, 32'd2);

        // R9 compare write leaves continuous count running
        setup(8'd0, 2'd3, 24'd20, 1'b0, 1'b0, 1'b1);
        run(10);
        wr(2'd1, 32'd30);
        run(3);
        chk("R9 continuous keeps running", {8'b0, snap}, 32'd13);

        // R14 suspend and resume
        setup(8'd0, 2'd1, 24'd100, 1'b0, 1'b0, 1'b1);
        run(8);
        wr(2'd0, cw(8'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        run(5);
        chk("R14 suspended inactive", {31'b0, active}, 32'd0);
        chk("R14 count held", {8'b0, snap}, 32'd9);
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        run(3);
        chk("R14 resumed from held count", {8'b0, snap}, 32'd11);

        // R10 soft reset
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
        chk("R10 soft reset stops", {31'b0, active}, 32'd0);
        rd(2'd0, d); chk("R10 run and reset bits read 0", {30'b0, d[14], d[8]}, 32'd0);
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        run(1);
        chk("R10 counter cleared", {8'b0, snap}, 32'd0);

        // R11 snapshot hold and follow
        setup(8'd0, 2'd1, 24'd100, 1'b0, 1'b0, 1'b1);
        run(6);
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        a = snap;
        chk("R11 last follow value", {8'b0, a}, 32'd6);
        run(7);
        chk("R11 snap held", {8'b0, snap}, {8'b0, a});
        chk("R11 still active", {31'b0, active}, 32'd1);
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        run(2);
        chk("R11 snap follows again", {8'b0, snap}, 32'd16);

        // R12 debug freeze
        setup(8'd0, 2'd3, 24'd1000, 1'b0, 1'b0, 1'b1);
        run(5);
        dbg_halt = 1'b1;
        run(3);
        a = snap;
        chk("R12 frozen value", {8'b0, a}, 32'd6);
        run(10);
        chk("R12 counter frozen", {8'b0, snap}, {8'b0, a});
        chk("R12 active while frozen", {31'b0, active}, 32'd1);
        dbg_halt = 1'b0;
        run(4);
        chk("R12 resumed", {8'b0, snap}, 32'd8);
        wr(2'd0, cw(8'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
        dbg_halt = 1'b1;
        run(2);
        a = snap;
        run(5);
        chk("R12 halt ignored", {8'b0, snap}, {8'b0, a + 24'd5});
        dbg_halt = 1'b0;

        // R7 set wins over a clear in the same cycle, then clear, then write 0
        setup(8'd0, 2'd1, 24'd5, 1'b1, 1'b0, 1'b1);
        run(9);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R7 set wins over clear", {31'b0, d[0]}, 32'd1);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R7 write 1 clears", {31'b0, d[0]}, 32'd0);
        chk("R8 irq low after clear", {31'b0, irq}, 32'd0);
        run(4);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R7 write 0 keeps flag", {31'b0, d[0]}, 32'd1);

        // R8 interrupt enable gating
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R8 irq masked", {31'b0, irq}, 32'd0);
        wr(2'd0, cw(8'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R8 irq unmasked", {31'b0, irq}, 32'd1);

        // R13 wake flag
        setup(8'd0, 2'd1, 24'd5, 1'b0, 1'b1, 1'b1);
        run(6);
        chk("R13 wake set on match", {31'b0, wake_flag}, 32'd1);
        wr(2'd2, 32'h2);
        chk("R13 wake cleared", {31'b0, wake_flag}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule